// File: doc/BRIEF.md
# Configurable-Top Timer Counter Unit

This block is the counting stage of a general-purpose timer. A clock-select stage turns one of five prescaler tap enables, or one chosen edge of an external pin, into a single-cycle tick. Each tick advances an up-counter. The counter wraps back to zero after its TOP value. TOP is either the largest value of the active width (8 or 16 bits) or a value taken from a compare input. The unit also drives a `top` indication and a sticky overflow request flag.

A register-style write port loads the counter directly. The overflow flag is cleared by a write-one strobe. The external pin passes through a two-flop synchronizer and then a two-state edge tracker. That tracker is the block's state machine. In state `PIN_LOW`, a synchronized high takes the `PIN_LOW -> PIN_HIGH` transition and produces a rising tick. In state `PIN_HIGH`, a synchronized low takes the `PIN_HIGH -> PIN_LOW` transition and produces a falling tick. Reset leaves the tracker in `PIN_LOW`.

Top module: `tmr_counter_unit`

## Requirements
- R1: On a tick, when the effective count is neither TOP nor the mode's maximum, the count becomes count + 1 on the next clock edge.
- R2: With `top_from_cmp` = 0, TOP is 0xFF when `wide_mode` = 0 and 0xFFFF when `wide_mode` = 1. A tick at TOP makes the count 0.
- R3: With `top_from_cmp` = 1, TOP is `cmp_val`, using only its low byte in 8-bit mode. A count above TOP keeps counting up to the mode maximum and then wraps to 0.
- R4: `clk_sel` code 0 stops the counter, which then holds its value. Codes 1 to 5 tick on prescaler taps `pre_taps[0]` to `pre_taps[4]` respectively.
- R5: `clk_sel` = 6 ticks on a falling edge of `ext_pin`, and 7 ticks on a rising edge. Each pin edge gives exactly one tick. The count changes on the third rising clock edge after the pin changes.
- R6: `at_top` is 1 exactly when the visible count equals the current TOP.
- R7: `ovf_flag` is set by a tick that wraps the count to 0. It then stays set until `ovf_clr` is pulsed. A wrap in the same cycle as `ovf_clr` leaves the flag set.
- R8: `wr_en` loads `wr_data` and overrides a tick in the same cycle. That cycle does not set `ovf_flag`. In 8-bit mode only the low byte of `wr_data` is loaded.
- R9: In 8-bit mode, `count[15:8]` reads as zero.
- R10: After reset, `count` is 0, `ovf_flag` is 0 and the edge tracker is in `PIN_LOW`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_sel | input | 3 | Tick source code (see R4, R5) |
| wide_mode | input | 1 | 1 = 16-bit counting, 0 = 8-bit |
| top_from_cmp | input | 1 | 1 = TOP from `cmp_val`, 0 = mode maximum |
| cmp_val | input | 16 | Programmable TOP value |
| ext_pin | input | 1 | Asynchronous external count pin |
| pre_taps | input | 5 | Single-cycle prescaler enables (divide by 1, 8, 64, 256, 1024) |
| wr_en | input | 1 | Counter load strobe |
| wr_data | input | 16 | Counter load value |
| ovf_clr | input | 1 | Overflow flag clear strobe |
| count | output | 16 | Visible count value |
| at_top | output | 1 | Count equals TOP |
| ovf_flag | output | 1 | Sticky overflow request |

## Verification
Two pairs of events can land in the same cycle. A counter load can meet a tick, and an overflow-clearing strobe can meet a wrapping tick. Directed steps create each pair on purpose: a load is issued while the divide-by-1 tap is held high, and `ovf_clr` is pulsed while the count sits at TOP with a tick pending. The result is judged against a bench model in which the load wins and the set wins. Constrained random traffic then mixes loads, clears, mode changes and pin toggles, so that both collisions also occur at random points.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int TAP_N = 5;

    typedef enum logic [2:0] {
        CS_OFF      = 3'd0,
        CS_TAP0     = 3'd1,
        CS_TAP1     = 3'd2,
        CS_TAP2     = 3'd3,
        CS_TAP3     = 3'd4,
        CS_TAP4     = 3'd5,
        CS_EXT_FALL = 3'd6,
        CS_EXT_RISE = 3'd7
    } clk_sel_e;

    typedef enum logic {
        PIN_LOW  = 1'b0,
        PIN_HIGH = 1'b1
    } pin_state_e;
endpackage

// File: rtl/tmr_pin_edge.sv
module tmr_pin_edge
    import tmr_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    logic [SYNC_N-1:0] sync_q;
    logic              pin_s;
    pin_state_e        state_q, state_d;

    // Synchronizer chain, one flop per stage
    generate
        for (genvar i = 0; i < SYNC_N; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n)
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= pin_i;
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n)
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
            end
        end
    endgenerate

    assign pin_s = sync_q[SYNC_N-1];

    // State register
    always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) state_q <= PIN_LOW;
        else        state_q <= state_d;

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        rise_o  = 1'b0;
        fall_o  = 1'b0;
        unique case (state_q)
            PIN_LOW: if (pin_s) begin
                state_d = PIN_HIGH;
                rise_o  = 1'b1;
            end
            PIN_HIGH: if (!pin_s) begin
                state_d = PIN_LOW;
                fall_o  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/tmr_tick_select.sv
module tmr_tick_select
    import tmr_pkg::*;
(
    input  clk_sel_e         sel_i,
    input  logic [TAP_N-1:0] taps_i,
    input  logic             ext_rise_i,
    input  logic             ext_fall_i,
    output logic             tick_o
);
    always_comb begin
        tick_o = 1'b0;
        unique case (sel_i)
            CS_OFF:      tick_o = 1'b0;
            CS_TAP0:     tick_o = taps_i[0];
            CS_TAP1:     tick_o = taps_i[1];
            CS_TAP2:     tick_o = taps_i[2];
            CS_TAP3:     tick_o = taps_i[3];
            CS_TAP4:     tick_o = taps_i[4];
            CS_EXT_FALL: tick_o = ext_fall_i;
            CS_EXT_RISE: tick_o = ext_rise_i;
        endcase
    end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
    parameter int CNT_W    = 16,
    parameter int NARROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wide_i,
    input  logic             top_cmp_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             wr_en_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic             ovf_clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             at_top_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] WIDE_MAX   = '1;
    localparam logic [CNT_W-1:0] NARROW_MAX = {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_eff, top_val, mode_max;
    logic             ovf_q, ovf_d, wrap;

    always_comb begin
        mode_max = wide_i ? WIDE_MAX : NARROW_MAX;
        cnt_eff  = cnt_q & mode_max;
        top_val  = top_cmp_i ? (cmp_i & mode_max) : mode_max;
        wrap     = (cnt_eff == top_val) || (cnt_eff == mode_max);

        if (wr_en_i)     cnt_d = wr_data_i & mode_max;
        else if (tick_i) cnt_d = wrap ? '0 : cnt_eff + 1'b1;
        else             cnt_d = cnt_q;

        ovf_d = (tick_i && !wr_en_i && wrap) || (ovf_q && !ovf_clr_i);
    end

    always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            ovf_q <= ovf_d;
        end

    assign count_o  = cnt_eff;
    assign at_top_o = (cnt_eff == top_val);
    assign ovf_o    = ovf_q;
endmodule

// File: rtl/tmr_counter_unit.sv
module tmr_counter_unit
    import tmr_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int NARROW_W = 8,
    parameter int SYNC_N   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       clk_sel,
    input  logic             wide_mode,
    input  logic             top_from_cmp,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             ext_pin,
    input  logic [TAP_N-1:0] pre_taps,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] count,
    output logic             at_top,
    output logic             ovf_flag
);
    logic ext_rise, ext_fall, tick;

    tmr_pin_edge #(.SYNC_N(SYNC_N)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_pin),
        .rise_o (ext_rise),
        .fall_o (ext_fall)
    );

    tmr_tick_select u_sel (
        .sel_i      (clk_sel_e'(clk_sel)),
        .taps_i     (pre_taps),
        .ext_rise_i (ext_rise),
        .ext_fall_i (ext_fall),
        .tick_o     (tick)
    );

    tmr_count_core #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .wide_i    (wide_mode),
        .top_cmp_i (top_from_cmp),
        .cmp_i     (cmp_val),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .ovf_clr_i (ovf_clr),
        .count_o   (count),
        .at_top_o  (at_top),
        .ovf_o     (ovf_flag)
    );
endmodule

// File: rtl/tmr_counter_chk.sv
module tmr_counter_chk #(
    parameter int CNT_W    = 16,
    parameter int NARROW_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       clk_sel,
    input logic             wide_mode,
    input logic             wr_en,
    input logic [CNT_W-1:0] wr_data,
    input logic             ovf_clr,
    input logic             tick,
    input logic [CNT_W-1:0] count,
    input logic             at_top,
    input logic             ovf_flag
);
    localparam logic [CNT_W-1:0] NARROW_MAX = {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    logic [CNT_W-1:0] mode_max;
    assign mode_max = wide_mode ? '1 : NARROW_MAX;

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 3'd0 && !wr_en) |=> ($stable(count) || wide_mode != $past(wide_mode))); // R4
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wide_mode) |=> (count == $past(wr_data) || !wide_mode)); // R8
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_mode |-> (count[CNT_W-1:NARROW_W] == '0)); // R9
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && at_top && !wr_en) |=> (count == '0)); // R2
    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && at_top && !wr_en) |=> ovf_flag); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag); // R7
    AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && !at_top && count != mode_max) |=>
        (wide_mode != $past(wide_mode) || count == $past(count) + 1'b1)); // R1
endmodule

bind tmr_counter_unit tmr_counter_chk #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_sel   (clk_sel),
    .wide_mode (wide_mode),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .ovf_clr   (ovf_clr),
    .tick      (tick),
    .count     (count),
    .at_top    (at_top),
    .ovf_flag  (ovf_flag)
);

// File: tb/sim_tmr_counter_unit.sv
`timescale 1ns/1ps
module sim_tmr_counter_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  clk_sel = 3'd0;
    logic        wide_mode = 1'b0;
    logic        top_from_cmp = 1'b0;
    logic [15:0] cmp_val = 16'd0;
    logic        ext_pin = 1'b0;
    logic [4:0]  pre_taps = 5'd0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'd0;
    logic        ovf_clr = 1'b0;
    logic [15:0] count;
    logic        at_top;
    logic        ovf_flag;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // bench model state
    logic [15:0] m_cnt = 16'd0;
    logic        m_ovf = 1'b0;
    logic        m_s1 = 1'b0, m_s2 = 1'b0, m_s3 = 1'b0;

    always #2.5 clk = ~clk;

    tmr_counter_unit u0 (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .wide_mode(wide_mode),
        .top_from_cmp(top_from_cmp), .cmp_val(cmp_val), .ext_pin(ext_pin),
        .pre_taps(pre_taps), .wr_en(wr_en), .wr_data(wr_data), .ovf_clr(ovf_clr),
        .count(count), .at_top(at_top), .ovf_flag(ovf_flag)
    );

    function automatic logic [15:0] f_max(input logic w);
        return w ? 16'hFFFF : 16'h00FF;
    endfunction

    function automatic logic [15:0] f_top(input logic w, input logic tc, input logic [15:0] c);
        return tc ? (c & f_max(w)) : f_max(w);
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_outputs(input string tag);
        logic [15:0] vis;
        vis = m_cnt & f_max(wide_mode);
        check(tag, count, vis);
        check("R6", {15'd0, at_top}, {15'd0, vis == f_top(wide_mode, top_from_cmp, cmp_val)});
        check("R7", {15'd0, ovf_flag}, {15'd0, m_ovf});
    endtask

    // Inputs already driven after a negedge; model one clock, then check.
    task automatic advance(input string tag);
        logic        tk, wrap;
        logic [15:0] eff, mx, tp, n_cnt;
        logic        n_ovf;
        mx  = f_max(wide_mode);
        tp  = f_top(wide_mode, top_from_cmp, cmp_val);
        eff = m_cnt & mx;
        case (clk_sel)
            3'd0: tk = 1'b0;
            3'd6: tk = ~m_s2 & m_s3;
            3'd7: tk = m_s2 & ~m_s3;
            default: tk = pre_taps[clk_sel - 3'd1];
        endcase
        wrap = (eff == tp) || (eff == mx);
        if (wr_en)   n_cnt = wr_data & mx;
        else if (tk) n_cnt = wrap ? 16'd0 : eff + 16'd1;
        else         n_cnt = m_cnt;
        n_ovf = (tk && !wr_en && wrap) || (m_ovf && !ovf_clr);
        @(posedge clk);
        m_cnt = n_cnt;
        m_ovf = n_ovf;
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
        @(negedge clk);
        check_outputs(tag);
    endtask

    task automatic quiet();
        wr_en = 0; ovf_clr = 0;
    endtask

    task automatic load(input logic [15:0] v, input string tag);
        wr_en = 1; wr_data = v;
        advance(tag);
        wr_en = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'd1234);
        repeat (4) @(negedge clk);
        rst_n = 1;
        check_outputs("R10");

        // R4: stopped, taps all active
        clk_sel = 3'd0; pre_taps = 5'h1F;
        repeat (5) advance("R4");
        // R4 tap selection: only tap 2 active, code 3
        clk_sel = 3'd3; pre_taps = 5'b00100;
        repeat (3) advance("R4");
        pre_taps = 5'b11011;
        repeat (3) advance("R4");

        // R1: divide-by-1 tap continuously
        clk_sel = 3'd1; pre_taps = 5'b00001;
        repeat (10) advance("R1");

        // R2 8-bit wrap and R7 flag
        load(16'h00FD, "R8");
        repeat (4) advance("R2");
        repeat (3) advance("R7");
        ovf_clr = 1; pre_taps = 5'd0; advance("R7"); ovf_clr = 0;

        // R9 / R8: 8-bit load keeps low byte only
        load(16'hABCD, "R9");
        advance("R9");

        // R2 16-bit wrap
        wide_mode = 1; pre_taps = 5'b00001;
        load(16'hFFFE, "R8");
        repeat (3) advance("R2");
        ovf_clr = 1; pre_taps = 5'd0; advance("R7"); ovf_clr = 0;

        // R3 compare top, 8-bit
        wide_mode = 0; top_from_cmp = 1; cmp_val = 16'h1205;
        load(16'h0000, "R3");
        pre_taps = 5'b00001;
        repeat (8) advance("R3");
        // above TOP: run to max then wrap
        load(16'h0009, "R3");
        repeat (250) advance("R3");

        // R8 write against tick in same cycle
        load(16'h0042, "R8");
        advance("R8");

        // R7 clear against wrap in same cycle
        pre_taps = 5'd0;
        load(16'h0005, "R7");
        ovf_clr = 1; pre_taps = 5'b00001; advance("R7");
        ovf_clr = 0; pre_taps = 5'd0; advance("R7");
        top_from_cmp = 0;

        // R5 external edges
        load(16'h0000, "R5");
        clk_sel = 3'd7;
        ext_pin = 1; repeat (5) advance("R5");
        ext_pin = 0; repeat (5) advance("R5");
        clk_sel = 3'd6;
        ext_pin = 1; repeat (5) advance("R5");
        ext_pin = 0; repeat (5) advance("R5");

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            quiet();
            if ($urandom_range(0, 49) == 0) clk_sel = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 199) == 0) wide_mode = ~wide_mode;
            if ($urandom_range(0, 149) == 0) top_from_cmp = ~top_from_cmp;
            if ($urandom_range(0, 99) == 0)
                cmp_val = wide_mode ? 16'($urandom_range(0, 600)) : 16'($urandom());
            pre_taps = 5'($urandom()) & 5'($urandom());
            if ($urandom_range(0, 3) == 0) ext_pin = ~ext_pin;
            if ($urandom_range(0, 31) == 0) begin
                wr_en = 1;
                wr_data = wide_mode && $urandom_range(0, 1) == 1 ? 16'hFFF0 + 16'($urandom_range(0, 15))
                                                                 : 16'($urandom());
            end
            if ($urandom_range(0, 39) == 0) ovf_clr = 1;
            advance("R1");
        end
        quiet();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule